// File: doc/BRIEF.md
# Synchronous differential clock stop controller

This block produces a set of differential clock pairs, each a logic-level true output and its complement, from one fast reference clock. Every pair runs at the same output period of `2*HALF` reference cycles. An active-low stop request halts the pairs that a per-pair mask marks as stoppable. The pairs left out of the mask keep toggling, and so does the rest of the clock system.

The request is asynchronous to the reference. It is sampled only on the reference edges where the internal complement phase rises, which are the edges where the true output falls. It passes through two such samples before it acts. A stoppable pair then parks at the start of its next high phase, with true high and complement low. On release the pair leaves the parked state at the edge where the true output would naturally fall. Neither stopping nor restarting ever produces a short or a stretched half period.

The stoppable mask is written with a single-cycle write strobe. It is a plain control input with no handshake. No data stream flows through the block, so there is no back-pressure to handle.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n` is low every `clk_t` bit is 0 and every `clk_c` bit is 1. The mask resets to all ones, so every pair is stoppable.
- R2: A running pair holds `clk_t` high for HALF reference cycles and low for HALF cycles, in turn. `clk_c` is the inverse of `clk_t` on every cycle.
- R3: `stop_req_n` is sampled only on reference edges where `clk_t` falls, and it passes through two such samples. A low pulse that covers none of those edges has no effect.
- R4: A stoppable pair parks with `clk_t`=1 and `clk_c`=0. Let P = 2*HALF, and count reference edges from the first edge after `stop_req_n` falls as edge 1. The pair's last rising edge on `clk_t` is then at edge P+HALF+1 at the earliest and at edge 2P+HALF at the latest.
- R5: A pair whose mask bit is 0 keeps toggling through a stop request.
- R6: Count reference edges from the first edge after `stop_req_n` rises as edge 1. A parked pair's first falling edge on `clk_t` is then at edge P+1 at the earliest and at edge 2P at the latest.
- R7: No phase is ever cut short. Every low phase of `clk_t` is exactly HALF cycles long. Every high phase is HALF + k*P cycles long for some k >= 0.
- R8: When `cfg_we` is high at a rising edge, `cfg_mask` is loaded into the mask. Mask bit i set to 1 makes pair i stoppable.
- R9: Clearing the mask bit of a parked pair leaves that pair parked until release. The pair then runs freely through later stops. Setting the bit of a running pair while a stop is active parks that pair at its next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_req_n | input | 1 | Active-low stop request, asynchronous to `clk` |
| cfg_we | input | 1 | Mask write strobe |
| cfg_mask | input | NPAIR | Stoppable mask value; bit i set makes pair i stoppable |
| clk_t | output | NPAIR | True outputs of the pairs |
| clk_c | output | NPAIR | Complement outputs of the pairs |

## Verification
The outputs are registered, so an output change shows up in the sample taken 3 ns after the reference edge that caused it. The bench time-stamps every edge against a cycle counter that increments on the rising reference edge. A stop acts between P+HALF+1 and 2P+HALF cycles after the request changes, and a release between P+1 and 2P cycles after it. These are windows rather than fixed cycles, because the request arrives at an unknown point of the output phase. The bench therefore records the last rising edge, or the first falling edge, during each stop or release phase and checks it against the window. A separate monitor checks every high and low phase width as the phase ends.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Strobes derived from the shared output phase counter, valid for the
  // reference edge about to occur.
  typedef struct packed {
    logic t_rise;   // edge that starts a high phase of the true output
    logic c_rise;   // edge that starts a low phase of the true output
    logic hi_nxt;   // nominal true level after the coming edge
  } phase_s;

endpackage

// File: rtl/clkstop_phase.sv
module clkstop_phase
  import clkstop_pkg::*;
#(
  parameter int HALF = 4,
  localparam int CW = $clog2(2 * HALF)
) (
  input  logic          clk,
  input  logic          rst_n,
  output phase_s        ph,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LAST  = CW'(2 * HALF - 1);
  localparam logic [CW-1:0] MID   = CW'(HALF - 1);
  localparam logic [CW-1:0] HALFV = CW'(HALF);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  always_comb begin
    cnt_n     = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    ph.t_rise = (cnt_q == LAST);
    ph.c_rise = (cnt_q == MID);
    ph.hi_nxt = (cnt_n < HALFV);
  end

  // Reset to the last count so the first edge opens a full high phase.
  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= LAST;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,   // complement-phase rising edge strobe
  input  logic req_n,       // raw asynchronous request, active low
  output logic stop_act,    // synchronized stop request, active high
  output logic rel_next     // last stage takes a released value at this sample
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         sh_q <= '1;
    else if (sample_en) sh_q <= {sh_q[STAGES-2:0], req_n};
  end

  assign stop_act = ~sh_q[STAGES-1];
  assign rel_next = sh_q[STAGES-2];

endmodule

// File: rtl/clkstop_cfg.sv
module clkstop_cfg #(
  parameter int NPAIR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [NPAIR-1:0] wdata,
  output logic [NPAIR-1:0] mask
);

  always_ff @(posedge clk) begin
    if (!rst_n)  mask <= '1;
    else if (we) mask <= wdata;
  end

endmodule

// File: rtl/clkstop_pair.sv
module clkstop_pair
  import clkstop_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_s ph,
  input  logic   stop_act,
  input  logic   rel_next,
  input  logic   stoppable,
  output logic   out_t,
  output logic   out_c,
  output logic   parked
);

  logic park_set;
  logic park_clr;
  logic parked_n;
  logic lvl_n;

  // Enter the parked state only at the start of a high phase, so the
  // parked level extends a full-width pulse.
  // Leave it only where the low phase would begin, so the first low
  // phase is also full width.
  always_comb begin
    park_set = ph.t_rise & stop_act & stoppable & ~parked;
    park_clr = ph.c_rise & rel_next & parked;
    parked_n = park_set | (parked & ~park_clr);
    lvl_n    = parked_n | ph.hi_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parked <= 1'b0;
      out_t  <= 1'b0;
      out_c  <= 1'b1;
    end else begin
      parked <= parked_n;
      out_t  <= lvl_n;
      out_c  <= ~lvl_n;
    end
  end

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int NPAIR       = 4,
  parameter int HALF        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req_n,
  input  logic             cfg_we,
  input  logic [NPAIR-1:0] cfg_mask,
  output logic [NPAIR-1:0] clk_t,
  output logic [NPAIR-1:0] clk_c
);

  localparam int CW = $clog2(2 * HALF);

  phase_s           ph_w;
  logic [CW-1:0]    cnt_w;
  logic             req_w;
  logic             rel_w;
  logic [NPAIR-1:0] mask_w;
  logic [NPAIR-1:0] parked_w;

  clkstop_phase #(.HALF(HALF)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .ph    (ph_w),
    .cnt_o (cnt_w)
  );

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (ph_w.c_rise),
    .req_n     (stop_req_n),
    .stop_act  (req_w),
    .rel_next  (rel_w)
  );

  clkstop_cfg #(.NPAIR(NPAIR)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_mask),
    .mask  (mask_w)
  );

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    clkstop_pair u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .ph        (ph_w),
      .stop_act  (req_w),
      .rel_next  (rel_w),
      .stoppable (mask_w[g]),
      .out_t     (clk_t[g]),
      .out_c     (clk_c[g]),
      .parked    (parked_w[g])
    );
  end

endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
  parameter int NPAIR = 4,
  parameter int HALF  = 4,
  localparam int CW = $clog2(2 * HALF)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPAIR-1:0] clk_t,
  input logic [NPAIR-1:0] clk_c,
  input logic [NPAIR-1:0] parked,
  input logic [CW-1:0]    cnt,
  input logic             req,
  input logic [NPAIR-1:0] mask
);

  for (genvar g = 0; g < NPAIR; g++) begin : g_chk
    p_complement_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clk_c[g] == !clk_t[g]);

    p_park_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      parked[g] |-> (clk_t[g] && !clk_c[g]));

    p_edge_on_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_t[g] != $past(clk_t[g])) |-> (cnt == '0 || cnt == CW'(HALF)));

    p_park_needs_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(parked[g]) |-> $past(req && mask[g]));

    p_resume_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(parked[g]) |-> !req);

    p_free_pair_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask[g] && !parked[g]) |=> !parked[g]);
  end

endmodule

bind clkstop_ctrl clkstop_chk #(.NPAIR(NPAIR), .HALF(HALF)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .clk_t  (clk_t),
  .clk_c  (clk_c),
  .parked (parked_w),
  .cnt    (cnt_w),
  .req    (req_w),
  .mask   (mask_w)
);

// File: tb/sim_clkstop_ctrl.sv
module sim_clkstop_ctrl;

  localparam int NP = 4;
  localparam int H  = 4;
  localparam int P  = 2 * H;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stop_n = 1'b1;
  logic          cfg_we = 1'b0;
  logic [NP-1:0] cfg_mask = '0;
  logic [NP-1:0] clk_t;
  logic [NP-1:0] clk_c;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  int m_chk = 0;
  int m_err = 0;
  logic [NP-1:0] mask_m = '1;

  clkstop_ctrl #(.NPAIR(NP), .HALF(H), .SYNC_STAGES(2)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req_n (stop_n),
    .cfg_we     (cfg_we),
    .cfg_mask   (cfg_mask),
    .clk_t      (clk_t),
    .clk_c      (clk_c)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Expected-value functions taken from the requirements.
  function automatic bit low_ok(int w);
    return w == H;
  endfunction
  function automatic bit high_ok(int w);
    return (w == H) || (w > H && ((w - H) % P) == 0);
  endfunction
  function automatic bit stop_lat_ok(int d);
    return d >= P + H + 1 && d <= 2 * P + H;
  endfunction
  function automatic bit rel_lat_ok(int d);
    return d >= P + 1 && d <= 2 * P;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  // Phase width monitor (R7) and complement check (R2).
  logic [NP-1:0] mon_prev = '0;
  int            mon_run[NP];
  bit            mon_started[NP];
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      for (int i = 0; i < NP; i++) begin
        m_chk++;
        if (clk_c[i] !== ~clk_t[i]) begin
          m_err++;
          $display("FAIL R2 complement pair %0d: actual %0d expected %0d", i, clk_c[i], ~clk_t[i]);
        end
        if (clk_t[i] !== mon_prev[i]) begin
          if (mon_started[i]) begin
            m_chk++;
            if (mon_prev[i] == 1'b0 && !low_ok(mon_run[i])) begin
              m_err++;
              $display("FAIL R7 low width pair %0d: actual %0d expected %0d", i, mon_run[i], H);
            end
            if (mon_prev[i] == 1'b1 && !high_ok(mon_run[i])) begin
              m_err++;
              $display("FAIL R7 high width pair %0d: actual %0d expected %0d", i, mon_run[i], H);
            end
          end
          mon_started[i] = 1'b1;
          mon_run[i] = 1;
        end else begin
          mon_run[i]++;
        end
        mon_prev[i] = clk_t[i];
      end
    end
  end

  task automatic write_mask(input logic [NP-1:0] m);
    cfg_mask = m;
    cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
    mask_m = m;
  endtask

  // Counts rising edges per pair over n cycles.
  task automatic count_rises(input int n, output int nr[NP]);
    logic [NP-1:0] pv;
    pv = clk_t;
    for (int i = 0; i < NP; i++) nr[i] = 0;
    repeat (n) begin
      tick();
      for (int i = 0; i < NP; i++) if (clk_t[i] && !pv[i]) nr[i]++;
      pv = clk_t;
    end
  endtask

  task automatic stop_phase(input int len);
    int t0;
    int last_rise[NP];
    int nr[NP];
    logic [NP-1:0] pv;
    pv = clk_t;
    t0 = cyc;
    stop_n = 1'b0;
    for (int i = 0; i < NP; i++) begin
      last_rise[i] = -1;
      nr[i] = 0;
    end
    repeat (len) begin
      tick();
      for (int i = 0; i < NP; i++) begin
        if (clk_t[i] && !pv[i]) begin
          last_rise[i] = cyc;
          nr[i]++;
        end
      end
      pv = clk_t;
    end
    for (int i = 0; i < NP; i++) begin
      if (mask_m[i]) begin
        check(clk_t[i] === 1'b1 && clk_c[i] === 1'b0, "R4 parked level", clk_t[i], 1);
        check(stop_lat_ok(last_rise[i] - t0), "R4 stop latency", last_rise[i] - t0, 2 * P + H);
      end else begin
        check(nr[i] >= len / P - 1, "R5 free pair toggles", nr[i], len / P - 1);
      end
    end
  endtask

  task automatic release_phase(input int len);
    int t1;
    int ff[NP];
    logic [NP-1:0] pv;
    pv = clk_t;
    t1 = cyc;
    stop_n = 1'b1;
    for (int i = 0; i < NP; i++) ff[i] = -1;
    repeat (len) begin
      tick();
      for (int i = 0; i < NP; i++)
        if (!clk_t[i] && pv[i] && ff[i] < 0) ff[i] = cyc;
      pv = clk_t;
    end
    for (int i = 0; i < NP; i++)
      if (mask_m[i])
        check(rel_lat_ok(ff[i] - t1), "R6 resume latency", ff[i] - t1, 2 * P);
  endtask

  task automatic summary(input int extra);
    $display("Simulation finished: %0d checks, %0d errors", n_chk + m_chk, n_err + m_err + extra);
  endtask

  initial begin
    #(8 * 150000);
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary(1);
    $finish;
  end

  initial begin
    int nr[NP];
    logic [NP-1:0] pv;
    void'($urandom(32'd20240611));

    // R1: levels held in reset
    repeat (3) tick();
    for (int i = 0; i < NP; i++)
      check(clk_t[i] === 1'b0 && clk_c[i] === 1'b1, "R1 reset levels", clk_t[i], 0);
    rst_n = 1'b1;
    count_rises(4 * P, nr);
    for (int i = 0; i < NP; i++) check(nr[i] == 4, "R2 running period", nr[i], 4);

    // R1: mask resets to all stoppable, with no write
    stop_phase(4 * P);
    check(clk_t === '1, "R1 reset mask stoppable", clk_t, (1 << NP) - 1);
    release_phase(3 * P);
    repeat (P) tick();

    // R3: short low pulse placed between two sampling edges
    pv = clk_t;
    do begin
      pv = clk_t;
      tick();
    end while (!(pv[0] && !clk_t[0]));
    stop_n = 1'b0;
    repeat (3) tick();
    stop_n = 1'b1;
    count_rises(3 * P, nr);
    for (int i = 0; i < NP; i++) check(nr[i] == 3, "R3 short pulse ignored", nr[i], 3);

    // R8: directed mask write
    write_mask(4'b0101);
    repeat (3 * P) tick();
    stop_phase(4 * P);
    count_rises(2 * P, nr);
    check(nr[1] == 2 && nr[3] == 2, "R8 unmasked pairs run", nr[1], 2);
    check(nr[0] == 0 && nr[2] == 0, "R8 masked pairs held", nr[0], 0);
    release_phase(3 * P);

    // Random stop/release sequences with random masks
    for (int k = 0; k < 24; k++) begin
      write_mask(NP'($urandom));
      repeat (3 * P) tick();
      stop_phase(3 * P + int'($urandom % (3 * P)));
      release_phase(3 * P + int'($urandom % P));
    end

    // R9: mask cleared while parked has no effect until restart
    write_mask('1);
    repeat (3 * P) tick();
    stop_phase(4 * P);
    write_mask(4'b1110);
    count_rises(2 * P, nr);
    check(nr[0] == 0 && clk_t[0] === 1'b1, "R9 parked ignores mask clear", nr[0], 0);
    release_phase(3 * P);
    repeat (P) tick();
    stop_phase(4 * P);
    count_rises(2 * P, nr);
    check(nr[0] == 2, "R9 cleared pair runs after restart", nr[0], 2);
    // R9: bit set while running under an active stop
    write_mask('1);
    repeat (2 * P) tick();
    count_rises(2 * P, nr);
    check(nr[0] == 0 && clk_t[0] === 1'b1, "R9 set bit parks running pair", nr[0], 0);
    release_phase(3 * P);
    repeat (2 * P) tick();

    summary(0);
    $finish;
  end

endmodule